// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block holds the configuration of a group of general-purpose I/O pins. Pins are organised in ports of 32. Each pin has two 32-bit words. The main word carries direction, output level, pull selection, buffer type, power gating, the alternate-function selector, a polarity flip for the alternate path and the input-path disable. The secondary word carries the slew and drive-strength settings. The bank sits on a plain read/write register bus and drives the per-pin pad controls. It also samples the pad inputs and returns them on read.

The output level of a pin can be seen in two places: bit 16 of the pin's main word, and bit n of its port's parallel output word. Both views come from a single stored bit, so they always agree. A per-pin write-select bit decides which view the bus may change. While a pin runs an alternate function, its stored level tracks the peripheral's output. Handing the pin back to plain GPIO therefore leaves the pad at the level it already had.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset, every main, secondary and parallel word reads zero when the pad inputs are low, and no pad output enable is asserted.
- R2: The word address is {region[1:0], port, pin[4:0]}. Region 0 is the main word, region 1 the secondary word, region 2 the parallel output word of the port, and region 3 reads zero. The register index is port*32+pin. A port at or above the configured count reads zero and ignores writes. Read data appears on bus_rdata one cycle after bus_rd is sampled.
- R3: Main word fields are: pull [1:0], power-off [2], open-drain [8], direction-out [9], output write-select [10], alternate invert [11], function select [14:12], output level [16], live input [24] (read-only), input disable [25]. Writable fields read back as written. All other bits read zero.
- R4: In the secondary word, bit 0 is slew (0 slow, 1 fast) and bits [5:4] are a zero-based drive strength. Both read back and drive pad_slew and pad_drv.
- R5: While bit 10 is clear, a main-word write of bit 16 sets the level in both views, and a parallel-word write leaves that pin unchanged.
- R6: While bit 10 is set, bit 16 of a main-word write is ignored, and a parallel-word write to bit n sets the level seen in both views. Bit 10 takes effect from the write after the one that sets it.
- R7: While the function select is nonzero, the stored level copies alt_out each cycle. A write that returns the select to zero keeps the pad at the alternate level it had, and ignores bit 16 in that same write.
- R8: Pull codes are 00 none, 01 weak up, 10 weak down and 11 keeper. Bit 0 drives pad_pu and bit 1 drives pad_pd.
- R9: pad_oe is asserted only when direction-out is set. In push-pull mode the pad drives the level. In open-drain mode pad_o is 0 and pad_oe is asserted only for a low level.
- R10: The pad input passes through two flops. A read that samples on the third rising edge after a pad change is the first to show it in bit 24. Bit 25 forces bit 24 to zero and drops pad_ie.
- R11: Bit 16 is stored and read back even while the pin is an input, without enabling the pad.
- R12: With power-off set, pad_oe stays low whatever the direction.
- R13: With a nonzero function select, the pad level is alt_out XOR bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 9 | Word address {region, port, pin} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 96 | Pad input levels |
| alt_out | input | 96 | Alternate-function output levels from peripherals |
| pad_o | output | 96 | Pad output level |
| pad_oe | output | 96 | Pad output enable |
| pad_ie | output | 96 | Pad input enable |
| pad_pu | output | 96 | Weak pull-up enable |
| pad_pd | output | 96 | Weak pull-down enable |
| pad_slew | output | 96 | Fast slew select |
| pad_drv | output | 192 | Drive strength, two bits per pin |

## Verification
A wrong stored output bit shows at once on pad_o of a driven pin. The next read of either the main word or the parallel word exposes it, so a mismatch between the two views cannot hide. A write-select sampled at the wrong time, or an alternate level that is not followed, changes pad_o on the cycle the function select returns to zero. A synchronizer that is one flop short or one flop long moves the first read showing a new pad level by exactly one cycle. Back-to-back reads catch that shift.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int unsigned PINS_PER_PORT = 32;
  localparam int unsigned PIN_W         = 5;
  localparam int unsigned MUX_W         = 3;
  localparam int unsigned DRV_W         = 2;

  // main word bit positions
  localparam int unsigned CB_PULL  = 0;
  localparam int unsigned CB_PGOFF = 2;
  localparam int unsigned CB_OD    = 8;
  localparam int unsigned CB_DIR   = 9;
  localparam int unsigned CB_AOD   = 10;
  localparam int unsigned CB_INV   = 11;
  localparam int unsigned CB_MUX   = 12;
  localparam int unsigned CB_OUT   = 16;
  localparam int unsigned CB_IN    = 24;
  localparam int unsigned CB_INDIS = 25;
  // secondary word bit positions
  localparam int unsigned C2_SLEW  = 0;
  localparam int unsigned C2_DRV   = 4;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_CTRL2 = 2'd1,
    REG_PAR   = 2'd2,
    REG_NONE  = 2'd3
  } region_e;

  typedef struct packed {
    logic [1:0]       pull;
    logic             pg_off;
    logic             od;
    logic             dir_out;
    logic             aod;
    logic             inv;
    logic [MUX_W-1:0] mux;
    logic             in_dis;
    logic             slew;
    logic [DRV_W-1:0] drv;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pin_cell.sv
`timescale 1ns/1ps
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_ctrl2,
  input  logic             wr_par,
  input  logic [31:0]      wdata,
  input  logic             par_bit,
  input  logic             alt_out,
  input  logic             in_sync,
  output logic [31:0]      ctrl_rd,
  output logic [31:0]      ctrl2_rd,
  output logic             out_bit,
  output logic             pad_o,
  output logic             pad_oe,
  output logic             pad_ie,
  output logic             pad_pu,
  output logic             pad_pd,
  output logic             pad_slew,
  output logic [DRV_W-1:0] pad_drv
);
  pin_cfg_t cfg_q, cfg_d;
  logic     outv_q, outv_d;
  logic     cfg_en;
  logic     alt_mode;
  logic     drive_val;
  logic     unused_wbits;

  assign unused_wbits = ^{wdata[31:26], wdata[24:17], wdata[15], wdata[7:6], wdata[3]};
  assign cfg_en   = wr_ctrl | wr_ctrl2;
  assign alt_mode = |cfg_q.mux;

  // next state
  always_comb begin
    cfg_d = cfg_q;
    if (wr_ctrl) begin
      cfg_d.pull    = wdata[CB_PULL +: 2];
      cfg_d.pg_off  = wdata[CB_PGOFF];
      cfg_d.od      = wdata[CB_OD];
      cfg_d.dir_out = wdata[CB_DIR];
      cfg_d.aod     = wdata[CB_AOD];
      cfg_d.inv     = wdata[CB_INV];
      cfg_d.mux     = wdata[CB_MUX +: MUX_W];
      cfg_d.in_dis  = wdata[CB_INDIS];
    end
    if (wr_ctrl2) begin
      cfg_d.slew = wdata[C2_SLEW];
      cfg_d.drv  = wdata[C2_DRV +: DRV_W];
    end
    if (alt_mode)                 outv_d = alt_out;
    else if (wr_ctrl && !cfg_q.aod) outv_d = wdata[CB_OUT];
    else if (wr_par && cfg_q.aod)   outv_d = par_bit;
    else                          outv_d = outv_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outv_q <= 1'b0;
    else        outv_q <= outv_d;
  end

  // pad side
  assign drive_val = alt_mode ? (alt_out ^ cfg_q.inv) : outv_q;
  assign pad_o     = cfg_q.od ? 1'b0 : drive_val;
  assign pad_oe    = cfg_q.dir_out & ~cfg_q.pg_off & (~cfg_q.od | ~drive_val);
  assign pad_ie    = ~cfg_q.in_dis;
  assign pad_pu    = cfg_q.pull[0];
  assign pad_pd    = cfg_q.pull[1];
  assign pad_slew  = cfg_q.slew;
  assign pad_drv   = cfg_q.drv;
  assign out_bit   = outv_q;

  // read views
  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[CB_PULL +: 2]       = cfg_q.pull;
    ctrl_rd[CB_PGOFF]           = cfg_q.pg_off;
    ctrl_rd[CB_OD]              = cfg_q.od;
    ctrl_rd[CB_DIR]             = cfg_q.dir_out;
    ctrl_rd[CB_AOD]             = cfg_q.aod;
    ctrl_rd[CB_INV]             = cfg_q.inv;
    ctrl_rd[CB_MUX +: MUX_W]    = cfg_q.mux;
    ctrl_rd[CB_OUT]             = outv_q;
    ctrl_rd[CB_IN]              = in_sync & ~cfg_q.in_dis;
    ctrl_rd[CB_INDIS]           = cfg_q.in_dis;
    ctrl2_rd                    = '0;
    ctrl2_rd[C2_SLEW]           = cfg_q.slew;
    ctrl2_rd[C2_DRV +: DRV_W]   = cfg_q.drv;
  end

  // R7: stored level tracks the alternate output while a function is selected
  p_alt_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alt_mode |=> (outv_q == $past(alt_out)));
  // R6: main-word write cannot change the level once write-select is set
  p_aod_blocks_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && cfg_q.aod && !wr_par && !alt_mode) |=> $stable(outv_q));
  // R5: parallel write cannot change the level while write-select is clear
  p_par_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_par && !cfg_q.aod && !wr_ctrl && !alt_mode) |=> $stable(outv_q));
endmodule

// File: rtl/gpio_pin_bank.sv
`timescale 1ns/1ps
module gpio_pin_bank
  import gpio_bank_pkg::*;
#(
  parameter  int unsigned NUM_PORTS = 3,
  localparam int unsigned PORT_W    = $clog2(NUM_PORTS + 1),
  localparam int unsigned IDX_W     = PORT_W + PIN_W,
  localparam int unsigned ADDR_W    = 2 + IDX_W,
  localparam int unsigned NPINS     = NUM_PORTS * PINS_PER_PORT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NPINS-1:0]       pad_in,
  input  logic [NPINS-1:0]       alt_out,
  output logic [NPINS-1:0]       pad_o,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NPINS-1:0]       pad_ie,
  output logic [NPINS-1:0]       pad_pu,
  output logic [NPINS-1:0]       pad_pd,
  output logic [NPINS-1:0]       pad_slew,
  output logic [DRV_W*NPINS-1:0] pad_drv
);
  localparam logic [PORT_W:0] PORT_LIM = (PORT_W + 1)'(NUM_PORTS);

  logic              rst_meta, rst_q;
  region_e           region;
  logic [PORT_W-1:0] port;
  logic [IDX_W-1:0]  idx;
  logic              port_ok;
  logic [NPINS-1:0]  in_sync;
  logic [NPINS-1:0]  out_bits;
  logic [31:0]       ctrl_rd_a  [NPINS];
  logic [31:0]       ctrl2_rd_a [NPINS];
  logic [31:0]       rd_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_meta} <= 2'b00;
    else        {rst_q, rst_meta} <= {rst_meta, 1'b1};
  end

  assign region  = region_e'(bus_addr[ADDR_W-1 -: 2]);
  assign port    = bus_addr[PIN_W +: PORT_W];
  assign idx     = bus_addr[IDX_W-1:0];
  assign port_ok = ({1'b0, port} < PORT_LIM);

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d     (pad_in),
    .q     (in_sync)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int unsigned MY_PORT = i / PINS_PER_PORT;
    localparam int unsigned MY_BIT  = i % PINS_PER_PORT;
    logic wr_ctrl, wr_ctrl2, wr_par;

    assign wr_ctrl  = bus_wr && (region == REG_CTRL)  && (idx == IDX_W'(i));
    assign wr_ctrl2 = bus_wr && (region == REG_CTRL2) && (idx == IDX_W'(i));
    assign wr_par   = bus_wr && (region == REG_PAR)   && (port == PORT_W'(MY_PORT));

    gpio_pin_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_q),
      .wr_ctrl  (wr_ctrl),
      .wr_ctrl2 (wr_ctrl2),
      .wr_par   (wr_par),
      .wdata    (bus_wdata),
      .par_bit  (bus_wdata[MY_BIT]),
      .alt_out  (alt_out[i]),
      .in_sync  (in_sync[i]),
      .ctrl_rd  (ctrl_rd_a[i]),
      .ctrl2_rd (ctrl2_rd_a[i]),
      .out_bit  (out_bits[i]),
      .pad_o    (pad_o[i]),
      .pad_oe   (pad_oe[i]),
      .pad_ie   (pad_ie[i]),
      .pad_pu   (pad_pu[i]),
      .pad_pd   (pad_pd[i]),
      .pad_slew (pad_slew[i]),
      .pad_drv  (pad_drv[i*DRV_W +: DRV_W])
    );
  end

  // read data next state
  always_comb begin
    rd_d = '0;
    if (port_ok) begin
      unique case (region)
        REG_CTRL: begin
          for (int i = 0; i < NPINS; i++)
            if (idx == IDX_W'(i)) rd_d = ctrl_rd_a[i];
        end
        REG_CTRL2: begin
          for (int i = 0; i < NPINS; i++)
            if (idx == IDX_W'(i)) rd_d = ctrl2_rd_a[i];
        end
        REG_PAR: begin
          for (int p = 0; p < NUM_PORTS; p++)
            if (port == PORT_W'(p)) rd_d = out_bits[p*PINS_PER_PORT +: PINS_PER_PORT];
        end
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end

  // R2: a read of a port beyond the configured count returns zero
  p_oor_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_rd && !port_ok) |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_pin_bank_tb.sv
`timescale 1ns/1ps
module gpio_pin_bank_tb;
  localparam int NP = 96;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_rd, bus_wr;
  logic [8:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pad_in, alt_out, pad_o, pad_oe, pad_ie, pad_pu, pad_pd, pad_slew;
  logic [2*NP-1:0] pad_drv;

  int n_cmp = 0;
  int n_mis = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gpio_pin_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .alt_out(alt_out), .pad_o(pad_o), .pad_oe(pad_oe),
    .pad_ie(pad_ie), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_slew(pad_slew),
    .pad_drv(pad_drv)
  );

  function automatic logic [8:0] A(input int r, input int p, input int n);
    return {2'(r), 2'(p), 5'(n)};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compare registered read data one cycle after each read
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(bus_rdata, 32'hx, "scoreboard underflow");
      else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_mis++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; alt_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk({31'b0, |pad_oe}, 32'd0, "R1 no oe after reset");
    rd(A(0,0,0), 32'h0, "R1 main word reset");
    rd(A(1,0,0), 32'h0, "R1 secondary word reset");
    rd(A(2,0,0), 32'h0, "R1 parallel word reset");

    // R3 full main-word write, function select left at zero
    wr(A(0,2,31), 32'hFFFF_8FFF);
    rd(A(0,2,31), 32'h0201_0F07, "R3 main word readback");
    chk({31'b0, pad_oe[95]}, 32'd0, "R12 power off blocks oe");
    chk({30'b0, pad_pd[95], pad_pu[95]}, 32'd3, "R8 keeper code 11");
    chk({31'b0, pad_ie[95]}, 32'd0, "R10 input disable drops pad_ie");

    // R2 addressing
    rd(A(0,1,31), 32'h0, "R2 neighbour index untouched");
    rd(A(2,2,0), 32'h8000_0000, "R5 parallel view of pin 95");
    wr(A(0,3,5), 32'hFFFF_FFFF);
    rd(A(0,3,5), 32'h0, "R2 out-of-range port reads zero");
    rd(A(3,0,0), 32'h0, "R2 region 3 reads zero");
    chk({31'b0, |pad_pu[63:0]}, 32'd0, "R2 out-of-range write ignored");

    // R4 secondary word
    wr(A(1,0,3), 32'hFFFF_FFFF);
    rd(A(1,0,3), 32'h0000_0031, "R4 secondary readback");
    chk({30'b0, pad_drv[7:6]}, 32'd3, "R4 drive strength pads");
    chk({31'b0, pad_slew[3]}, 32'd1, "R4 fast slew pad");

    // R5 write-select clear
    wr(A(0,0,1), 32'h0001_0200);
    chk({30'b0, pad_oe[1], pad_o[1]}, 32'd3, "R9 push-pull drives high");
    wr(A(2,0,0), 32'h0);
    chk({31'b0, pad_o[1]}, 32'd1, "R5 parallel write ignored");
    rd(A(2,0,0), 32'h0000_0002, "R5 parallel view after ignored write");

    // R6 write-select set
    wr(A(0,0,1), 32'h0001_0600);
    wr(A(0,0,1), 32'h0000_0600);
    chk({31'b0, pad_o[1]}, 32'd1, "R6 main-word level ignored");
    rd(A(0,0,1), 32'h0001_0600, "R6 main word keeps level");
    wr(A(2,0,0), 32'h0);
    chk({31'b0, pad_o[1]}, 32'd0, "R6 parallel write takes effect");
    rd(A(0,0,1), 32'h0000_0600, "R6 main word shows parallel write");

    // R13 / R7 alternate function
    alt_out[32] = 1'b1;
    wr(A(0,1,0), 32'h0000_2200);
    chk({30'b0, pad_oe[32], pad_o[32]}, 32'd3, "R13 alt level on pad");
    wr(A(0,1,0), 32'h0000_2A00);
    chk({31'b0, pad_o[32]}, 32'd0, "R13 inverted alt level");
    wr(A(0,1,0), 32'h0000_2200);
    rd(A(2,1,0), 32'h0000_0001, "R7 parallel bit follows alt");
    wr(A(0,1,0), 32'h0000_0200);
    chk({31'b0, pad_o[32]}, 32'd1, "R7 no glitch on return to gpio");
    rd(A(0,1,0), 32'h0001_0200, "R7 level kept after return");

    // R12 / R9 power gate and open drain
    wr(A(0,0,7), 32'h0001_0204);
    chk({31'b0, pad_oe[7]}, 32'd0, "R12 power off with direction out");
    wr(A(0,0,7), 32'h0001_0300);
    chk({30'b0, pad_oe[7], pad_o[7]}, 32'd0, "R9 open drain releases high");
    wr(A(0,0,7), 32'h0000_0300);
    chk({30'b0, pad_oe[7], pad_o[7]}, 32'd2, "R9 open drain drives low");

    // R11 level while input
    wr(A(0,0,9), 32'h0001_0000);
    rd(A(0,0,9), 32'h0001_0000, "R11 level stored while input");
    chk({31'b0, pad_oe[9]}, 32'd0, "R9 no oe while input");
    rd(A(2,0,0), 32'h0000_0200, "R11 parallel view while input");

    // R8 pull codes
    wr(A(0,0,10), 32'h1);
    chk({30'b0, pad_pd[10], pad_pu[10]}, 32'd1, "R8 pull-up code 01");
    wr(A(0,0,10), 32'h2);
    chk({30'b0, pad_pd[10], pad_pu[10]}, 32'd2, "R8 pull-down code 10");
    wr(A(0,0,10), 32'h0);
    chk({30'b0, pad_pd[10], pad_pu[10]}, 32'd0, "R8 no pull code 00");

    // R10 synchronizer latency and input disable
    pad_in[12] = 1'b1;
    rd(A(0,0,12), 32'h0, "R10 first edge not visible");
    rd(A(0,0,12), 32'h0, "R10 second edge not visible");
    rd(A(0,0,12), 32'h0100_0000, "R10 third edge visible");
    chk({31'b0, pad_ie[12]}, 32'd1, "R10 pad_ie while enabled");
    wr(A(0,0,12), 32'h0200_0000);
    rd(A(0,0,12), 32'h0200_0000, "R10 disabled input reads zero");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk(32'(exp_q.size()), 32'd0, "scoreboard leftover");
    summary();
  end
endmodule